// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit sits in the execute stage of a processor pipeline. For every load or store it forms the memory address and, when the instruction asks for base writeback, the new base register value. It supports three addressing modes: a plain immediate offset, pre-indexed with writeback, and post-indexed with writeback. It also decides whether the encoding is legal, using rules on offset range, offset alignment and register combinations. Each rule depends on the mode, the access size and the direction of the transfer. The address and writeback results are combinational and use 32-bit wraparound arithmetic. The unit never touches condition flags, so it has no flag output.

A legal word load whose destination is the program counter becomes an interworking branch. A two-state machine tracks it. In `ST_IDLE` the unit accepts the load, and the transition "PC load accepted" moves it to `ST_WAIT_PC`. In `ST_WAIT_PC` it waits for the loaded value, and the transition "data returned" takes it back to `ST_IDLE`. On that return it either requests a branch to the value with bit 0 cleared, or raises a fault when bit 0 of the value is clear. Memory access, the register file and pipeline control are outside this unit.

Top module: `ldst_agu`

## Requirements
- R1: Encodings are: mode 0 = immediate offset, 1 = pre-indexed, 2 = post-indexed, 3 = reserved (always illegal); size 0 = byte, 1 = halfword, 2 = word, 3 = doubleword pair. In mode 0, `eff_addr` = base + sign-extended offset (mod 2^32) and `wb_en` is 0.
- R2: In pre-indexed mode, `eff_addr` and `wb_val` both equal base + offset (mod 2^32).
- R3: In post-indexed mode, `eff_addr` equals the unmodified base and `wb_val` equals base + offset (mod 2^32). `wb_val` always carries base + offset.
- R4: For sizes 0 to 2, a legal offset lies in -255..4095 in mode 0 and in -255..255 in modes 1 and 2. Any offset outside that range sets `illegal`.
- R5: For size 3, a legal offset is a multiple of 4 within -1020..1020 in every mode. Any other offset sets `illegal`.
- R6: A doubleword load with `rt_idx == rt2_idx` is illegal. In modes 1 and 2, `rn_idx` equal to `rt_idx`, or to `rt2_idx` for size 3, is illegal.
- R7: A store with `rt_idx` = 15 (program counter) or `rn_idx` = 15 is illegal. A store with `rt_idx` = 13 (stack pointer) is illegal unless size is 2.
- R8: A load with `rt_idx` of 13 or 15 is illegal unless size is 2. For size 3 in either direction, `rt2_idx` of 13 or 15 is illegal.
- R9: A word load into register 15 with `in_cond_blk` = 1 and `cond_last` = 0 is illegal.
- R10: After a legal word load into register 15 is issued, the next cycle with `ld_data_valid` = 1 produces one of two results in that same cycle. If the data has bit 0 set, `branch_req` = 1 with `branch_target` = data with bit 0 cleared. If bit 0 is clear, `pc_fault` = 1 instead. Load data that arrives with no such load pending produces neither. Both outputs are 0 after reset.
- R11: `illegal` and `wb_en` are 0 when `issue_valid` is 0. `wb_en` is 1 exactly for a valid, legal instruction in mode 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| mode | input | 2 | Addressing mode |
| size | input | 2 | Access size |
| is_load | input | 1 | 1 = load, 0 = store |
| rn_idx | input | 4 | Base register index |
| rt_idx | input | 4 | First transfer register index |
| rt2_idx | input | 4 | Second transfer register index (doubleword) |
| in_cond_blk | input | 1 | Instruction sits inside a conditional-execution block |
| cond_last | input | 1 | Instruction is the last one of that block |
| base_val | input | 32 | Base register value |
| imm_off | input | 13 | Signed immediate offset |
| ld_data_valid | input | 1 | Loaded value is presented |
| ld_data | input | 32 | Loaded value |
| eff_addr | output | 32 | Access address |
| wb_val | output | 32 | Base writeback value |
| wb_en | output | 1 | Base writeback enable |
| illegal | output | 1 | Encoding is illegal |
| branch_req | output | 1 | Interworking branch request |
| branch_target | output | 32 | Branch target with bit 0 cleared |
| pc_fault | output | 1 | Program-counter load delivered a bit-0-clear value |

## Verification
Most of the unit is combinational. A wrong legality term or adder input shows up on `illegal`, `wb_en`, `eff_addr` or `wb_val` in the same cycle the instruction is presented, so the sweep catches it at once. The state machine is the only internal state. If it is stuck in or out of `ST_WAIT_PC`, `branch_req` or `pc_fault` is missing or spurious in the first data-return cycle after the load, one clock after issue.

// File: rtl/ldst_agu_pkg.sv
package ldst_agu_pkg;

    typedef enum logic [1:0] {
        AM_OFFSET = 2'd0,
        AM_PRE    = 2'd1,
        AM_POST   = 2'd2,
        AM_RSVD   = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        AS_BYTE = 2'd0,
        AS_HALF = 2'd1,
        AS_WORD = 2'd2,
        AS_DUAL = 2'd3
    } asize_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_WAIT_PC = 1'b1
    } pcst_e;

endpackage

// File: rtl/ldst_agu_addr.sv
module ldst_agu_addr
    import ldst_agu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 13
) (
    input  amode_e                   mode_i,
    input  logic [ADDR_W-1:0]        base_i,
    input  logic signed [IMM_W-1:0]  imm_i,
    output logic [ADDR_W-1:0]        addr_o,
    output logic [ADDR_W-1:0]        sum_o
);
    localparam int EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] imm_ext;

    assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    assign sum_o   = base_i + imm_ext;

    always_comb begin
        unique case (mode_i)
            AM_POST: addr_o = base_i;
            default: addr_o = sum_o;
        endcase
    end
endmodule

// File: rtl/ldst_agu_legal.sv
module ldst_agu_legal
    import ldst_agu_pkg::*;
#(
    parameter int IMM_W      = 13,
    parameter int RIDX_W     = 4,
    parameter int PC_NUM     = 15,
    parameter int SP_NUM     = 13,
    parameter int SGL_NEG    = 255,
    parameter int SGL_POS    = 4095,
    parameter int IDX_POS    = 255,
    parameter int DUAL_LIM   = 1020
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_i,
    input  amode_e                   mode_i,
    input  asize_e                   size_i,
    input  logic                     load_i,
    input  logic [RIDX_W-1:0]        rn_i,
    input  logic [RIDX_W-1:0]        rt_i,
    input  logic [RIDX_W-1:0]        rt2_i,
    input  logic                     in_cond_i,
    input  logic                     cond_last_i,
    input  logic signed [IMM_W-1:0]  imm_i,
    output logic                     illegal_o,
    output logic                     pc_load_o
);
    localparam logic [RIDX_W-1:0] PC_IDX = RIDX_W'(PC_NUM);
    localparam logic [RIDX_W-1:0] SP_IDX = RIDX_W'(SP_NUM);

    int   off_v;
    logic dual, wback, bad_off, bad_reg, pc_word_ld, bad_cond;

    assign off_v      = int'(imm_i);
    assign dual       = (size_i == AS_DUAL);
    assign wback      = (mode_i == AM_PRE) || (mode_i == AM_POST);
    assign pc_word_ld = load_i && (size_i == AS_WORD) && (rt_i == PC_IDX);
    assign bad_cond   = pc_word_ld && in_cond_i && !cond_last_i;

    always_comb begin
        bad_off = 1'b0;
        if (mode_i == AM_RSVD)
            bad_off = 1'b1;
        if (dual) begin
            if ((imm_i[1:0] != 2'b00) || (off_v < -DUAL_LIM) || (off_v > DUAL_LIM))
                bad_off = 1'b1;
        end else if (mode_i == AM_OFFSET) begin
            if ((off_v < -SGL_NEG) || (off_v > SGL_POS))
                bad_off = 1'b1;
        end else begin
            if ((off_v < -SGL_NEG) || (off_v > IDX_POS))
                bad_off = 1'b1;
        end
    end

    always_comb begin
        bad_reg = 1'b0;
        if (dual && load_i && (rt_i == rt2_i))
            bad_reg = 1'b1;                                       // R6
        if (wback && ((rn_i == rt_i) || (dual && (rn_i == rt2_i))))
            bad_reg = 1'b1;                                       // R6
        if (!load_i && ((rt_i == PC_IDX) || (rn_i == PC_IDX)))
            bad_reg = 1'b1;                                       // R7
        if (((rt_i == SP_IDX) || (rt_i == PC_IDX)) && (size_i != AS_WORD))
            bad_reg = 1'b1;                                       // R7, R8
        if (dual && ((rt2_i == SP_IDX) || (rt2_i == PC_IDX)))
            bad_reg = 1'b1;                                       // R8
    end

    assign illegal_o = valid_i && (bad_off || bad_reg || bad_cond);
    assign pc_load_o = valid_i && !illegal_o && pc_word_ld;

    AST_DUAL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && dual && !illegal_o) |-> (imm_i[1:0] == 2'b00)); // R5
    AST_COND_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load_o && in_cond_i) |-> cond_last_i);                  // R9
endmodule

// File: rtl/ldst_agu_pcbr.sv
module ldst_agu_pcbr
    import ldst_agu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              data_vld_i,
    input  logic [ADDR_W-1:0] data_i,
    output logic              branch_o,
    output logic [ADDR_W-1:0] target_o,
    output logic              fault_o
);
    pcst_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (go_i)       state_nx = ST_WAIT_PC;
            ST_WAIT_PC: if (data_vld_i) state_nx = ST_IDLE;
            default:                    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        branch_o = 1'b0;
        fault_o  = 1'b0;
        target_o = {data_i[ADDR_W-1:1], 1'b0};
        unique case (state)
            ST_IDLE: ;
            ST_WAIT_PC: begin
                branch_o = data_vld_i &&  data_i[0];
                fault_o  = data_vld_i && !data_i[0];
            end
            default: ;
        endcase
    end

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({branch_o, fault_o}));                                // R10
    AST_WAIT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_PC && $past(state) == ST_IDLE) |-> $past(go_i)); // R10
    AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_PC && data_vld_i) |=> (state == ST_IDLE));  // R10
endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
    import ldst_agu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 13,
    parameter int RIDX_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue_valid,
    input  logic [1:0]               mode,
    input  logic [1:0]               size,
    input  logic                     is_load,
    input  logic [RIDX_W-1:0]        rn_idx,
    input  logic [RIDX_W-1:0]        rt_idx,
    input  logic [RIDX_W-1:0]        rt2_idx,
    input  logic                     in_cond_blk,
    input  logic                     cond_last,
    input  logic [ADDR_W-1:0]        base_val,
    input  logic signed [IMM_W-1:0]  imm_off,
    input  logic                     ld_data_valid,
    input  logic [ADDR_W-1:0]        ld_data,
    output logic [ADDR_W-1:0]        eff_addr,
    output logic [ADDR_W-1:0]        wb_val,
    output logic                     wb_en,
    output logic                     illegal,
    output logic                     branch_req,
    output logic [ADDR_W-1:0]        branch_target,
    output logic                     pc_fault
);
    amode_e mode_e;
    asize_e size_e;
    logic   pc_go;

    assign mode_e = amode_e'(mode);
    assign size_e = asize_e'(size);

    ldst_agu_addr #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_addr (
        .mode_i (mode_e),
        .base_i (base_val),
        .imm_i  (imm_off),
        .addr_o (eff_addr),
        .sum_o  (wb_val)
    );

    ldst_agu_legal #(.IMM_W(IMM_W), .RIDX_W(RIDX_W)) u_legal (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (issue_valid),
        .mode_i      (mode_e),
        .size_i      (size_e),
        .load_i      (is_load),
        .rn_i        (rn_idx),
        .rt_i        (rt_idx),
        .rt2_i       (rt2_idx),
        .in_cond_i   (in_cond_blk),
        .cond_last_i (cond_last),
        .imm_i       (imm_off),
        .illegal_o   (illegal),
        .pc_load_o   (pc_go)
    );

    ldst_agu_pcbr #(.ADDR_W(ADDR_W)) u_pcbr (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (pc_go),
        .data_vld_i (ld_data_valid),
        .data_i     (ld_data),
        .branch_o   (branch_req),
        .target_o   (branch_target),
        .fault_o    (pc_fault)
    );

    assign wb_en = issue_valid && !illegal &&
                   ((mode_e == AM_PRE) || (mode_e == AM_POST));

    AST_WB_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (issue_valid && !illegal));                           // R11
    AST_PRE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && mode_e == AM_PRE) |-> (eff_addr == wb_val));    // R2
    AST_POST_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && mode_e == AM_POST) |-> (eff_addr == base_val)); // R3
endmodule

// File: tb/test_ldst_agu.sv
module test_ldst_agu;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               issue_valid = 1'b0;
    logic [1:0]         mode = 2'd0;
    logic [1:0]         size = 2'd0;
    logic               is_load = 1'b0;
    logic [3:0]         rn_idx = 4'd0, rt_idx = 4'd0, rt2_idx = 4'd0;
    logic               in_cond_blk = 1'b0, cond_last = 1'b0;
    logic [31:0]        base_val = 32'd0;
    logic signed [12:0] imm_off = 13'sd0;
    logic               ld_data_valid = 1'b0;
    logic [31:0]        ld_data = 32'd0;
    logic [31:0]        eff_addr, wb_val, branch_target;
    logic               wb_en, illegal, branch_req, pc_fault;

    int  n_chk = 0, n_bad = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    ldst_agu i_ldst_agu (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .mode(mode), .size(size),
        .is_load(is_load), .rn_idx(rn_idx), .rt_idx(rt_idx), .rt2_idx(rt2_idx),
        .in_cond_blk(in_cond_blk), .cond_last(cond_last), .base_val(base_val),
        .imm_off(imm_off), .ld_data_valid(ld_data_valid), .ld_data(ld_data),
        .eff_addr(eff_addr), .wb_val(wb_val), .wb_en(wb_en), .illegal(illegal),
        .branch_req(branch_req), .branch_target(branch_target), .pc_fault(pc_fault)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit exp_bad(int m, int s, bit ld, int rn, int rt, int rt2,
                                   int off, bit inc, bit last);
        bit b = 0;
        if (m == 3) b = 1;
        if (s == 3) begin
            if ((off % 4) != 0 || off < -1020 || off > 1020) b = 1;
        end else if (m == 0) begin
            if (off < -255 || off > 4095) b = 1;
        end else begin
            if (off < -255 || off > 255) b = 1;
        end
        if (s == 3 && ld && rt == rt2) b = 1;
        if ((m == 1 || m == 2) && (rn == rt || (s == 3 && rn == rt2))) b = 1;
        if (!ld && (rt == 15 || rn == 15)) b = 1;
        if ((rt == 13 || rt == 15) && s != 2) b = 1;
        if (s == 3 && (rt2 == 13 || rt2 == 15)) b = 1;
        if (ld && s == 2 && rt == 15 && inc && !last) b = 1;
        return b;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        issue_valid = 1'b0;
        ld_data_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pc_load_issue(bit inc, bit last);
        @(negedge clk);
        issue_valid = 1'b1; mode = 2'd0; size = 2'd2; is_load = 1'b1;
        rn_idx = 4'd1; rt_idx = 4'd15; rt2_idx = 4'd2; imm_off = 13'sd8;
        in_cond_blk = inc; cond_last = last; base_val = 32'h2000_0000;
        #1;
    endtask

    task automatic data_return(logic [31:0] d);
        @(negedge clk);
        issue_valid = 1'b0; in_cond_blk = 1'b0; cond_last = 1'b0;
        ld_data_valid = 1'b1; ld_data = d;
        #1;
    endtask

    initial begin
        int offs[20] = '{-4096, -1024, -1021, -1020, -1016, -256, -255, -254, -1, 0,
                         1, 2, 4, 255, 256, 1020, 1021, 1024, 4092, 4095};
        int regs[4]  = '{0, 5, 13, 15};
        int iter = 0;
        do_reset();
        #1;
        chk("R10 reset branch_req", 32'(branch_req), 32'd0);
        chk("R10 reset pc_fault", 32'(pc_fault), 32'd0);

        // Sweep of modes, sizes, direction, offsets and register combinations
        for (int m = 0; m < 4; m++)
          for (int s = 0; s < 4; s++)
            for (int ld = 0; ld < 2; ld++)
              for (int oi = 0; oi < 20; oi++)
                for (int a = 0; a < 4; a++)
                  for (int b = 0; b < 4; b++)
                    for (int c = 0; c < 4; c++) begin
                        bit eb;
                        logic [31:0] sum;
                        string mt;
                        iter++;
                        issue_valid = 1'b1; mode = 2'(m); size = 2'(s); is_load = ld[0];
                        rn_idx = 4'(regs[a]); rt_idx = 4'(regs[b]); rt2_idx = 4'(regs[c]);
                        imm_off = 13'(offs[oi]); in_cond_blk = 1'b0; cond_last = 1'b0;
                        base_val = 32'(iter) * 32'h9E37_79B9 + 32'hFFFF_F800;
                        #1;
                        eb  = exp_bad(m, s, ld[0], regs[a], regs[b], regs[c], offs[oi], 1'b0, 1'b0);
                        sum = base_val + 32'(offs[oi]);
                        mt  = (m == 2) ? "R3" : ((m == 1) ? "R2" : "R1");
                        chk("R4/R5/R6/R7/R8 illegal", 32'(illegal), 32'(eb));
                        chk({mt, " eff_addr"}, eff_addr, (m == 2) ? base_val : sum);
                        chk("R3 wb_val", wb_val, sum);
                        chk({"R11 ", mt, " wb_en"}, 32'(wb_en),
                            32'(!eb && (m == 1 || m == 2)));
                    end

        // R11: no issue means no flag and no writeback
        issue_valid = 1'b0; mode = 2'd1; size = 2'd3; rn_idx = 4'd15; imm_off = 13'sd3;
        #1;
        chk("R11 idle illegal", 32'(illegal), 32'd0);
        chk("R11 idle wb_en", 32'(wb_en), 32'd0);

        // R10 interworking branch
        do_reset();
        pc_load_issue(1'b0, 1'b0);
        chk("R10 pc load legal", 32'(illegal), 32'd0);
        data_return(32'h0000_1235);
        chk("R10 branch_req", 32'(branch_req), 32'd1);
        chk("R10 branch_target", branch_target, 32'h0000_1234);
        chk("R10 no fault", 32'(pc_fault), 32'd0);
        // R10 bit-0-clear fault
        @(negedge clk); ld_data_valid = 1'b0;
        pc_load_issue(1'b0, 1'b0);
        data_return(32'h8000_0010);
        chk("R10 fault", 32'(pc_fault), 32'd1);
        chk("R10 no branch on even", 32'(branch_req), 32'd0);
        // R10 data with nothing pending is ignored
        data_return(32'h0000_0777);
        chk("R10 stray data branch", 32'(branch_req), 32'd0);
        chk("R10 stray data fault", 32'(pc_fault), 32'd0);
        // R9 misplaced conditional PC load
        @(negedge clk); ld_data_valid = 1'b0;
        pc_load_issue(1'b1, 1'b0);
        chk("R9 misplaced illegal", 32'(illegal), 32'd1);
        chk("R9 misplaced wb_en", 32'(wb_en), 32'd0);
        data_return(32'h0000_0101);
        chk("R9 misplaced no branch", 32'(branch_req), 32'd0);
        // R9 last in block is legal
        @(negedge clk); ld_data_valid = 1'b0;
        pc_load_issue(1'b1, 1'b1);
        chk("R9 last legal", 32'(illegal), 32'd0);
        data_return(32'h0000_0101);
        chk("R9 last branch", 32'(branch_req), 32'd1);
        chk("R9 last target", branch_target, 32'h0000_0100);
        @(negedge clk); ld_data_valid = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule